// File: doc/BRIEF.md
# Neighbor-Linked Register Queue

This block is a bank of 128 words of 32 bits that an execution engine can use in one of two ways. In local mode the bank is a private extension of the engine's general registers: the engine writes any word by address and reads any word by address. In neighbor mode the same bank becomes a circular queue between two engines. The engine upstream pushes words into it, and the owning engine pops them off.

In neighbor mode two index registers drive the queue. A put index marks the slot where the next pushed word lands. A get index marks the word the next pop returns. Each index moves forward by one, wrapping at the bank size, every time a push or pop is accepted. Software can load either index directly, so it can set up or rewind the queue. Two flags show the occupancy. The queue counts as full at one slot short of the bank size, so that equal indices always mean empty.

Switching the mode clears both indices, so every queue starts empty.

Top module: `nbr_queue_top`

## Requirements
- R1: After reset the mode is local (`mode_o` = 0), both indices are 0, `empty_o` is 1, `full_o` is 0, and every stored word reads as 0.
- R2: In local mode, `loc_we_i` writes `loc_wdata_i` to the word at `loc_waddr_i` at the clock edge. In either mode, `loc_rdata_o` shows the word at `loc_raddr_i` with no clock delay.
- R3: In neighbor mode, a push while not full stores `push_data_i` at the put index. The put index then becomes put+1 modulo 128 on the next cycle.
- R4: In neighbor mode, `pop_data_o` shows the word at the get index with no clock delay. A pop while not empty makes the get index get+1 modulo 128 on the next cycle.
- R5: `empty_o` is 1 exactly when put equals get. `full_o` is 1 exactly when (put+1) modulo 128 equals get, which means 127 words are held.
- R6: A push while full is dropped: the put index and the stored words stay unchanged.
- R7: A pop while empty is ignored: the get index stays unchanged.
- R8: A push and a pop in the same cycle, with the queue neither empty nor full, both take effect in that cycle.
- R9: `put_we_i` loads `idx_wdata_i` into the put index, and `get_we_i` loads it into the get index. Each load wins over that index's auto-advance in the same cycle, and both loads work in either mode.
- R10: In a cycle where `mode_i` (0 = local, 1 = neighbor) differs from `mode_o`, the next cycle has `mode_o` = `mode_i` and both indices at 0. No write or index update from that cycle takes effect.
- R11: In local mode, push and pop have no effect on the words or the indices. In neighbor mode, `loc_we_i` has no effect on the words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| mode_i | input | 1 | Requested mode: 0 local, 1 neighbor |
| loc_we_i | input | 1 | Local write enable |
| loc_waddr_i | input | 7 | Local write address |
| loc_wdata_i | input | 32 | Local write data |
| loc_raddr_i | input | 7 | Local read address |
| loc_rdata_o | output | 32 | Local read data |
| push_i | input | 1 | Upstream push request |
| push_data_i | input | 32 | Upstream push data |
| pop_i | input | 1 | Local pop request |
| pop_data_o | output | 32 | Word at the get index |
| put_we_i | input | 1 | Software load of the put index |
| get_we_i | input | 1 | Software load of the get index |
| idx_wdata_i | input | 7 | Value for index loads |
| put_idx_o | output | 7 | Current put index |
| get_idx_o | output | 7 | Current get index |
| empty_o | output | 1 | Queue empty flag |
| full_o | output | 1 | Queue full flag |
| mode_o | output | 1 | Mode in effect |

## Verification
A wrong index shows up on the index ports one cycle after the faulty edge. The flags follow straight from the indices, so a wrong index also shows as a wrong flag at once. A word stored in the wrong slot or dropped stays hidden until that slot is read back, either by a pop that reaches it or by a local read. For that reason the bench compares `pop_data_o` and `loc_rdata_o` against a model of the bank on every cycle. It also drains full queues and walks across the wrap point, so that every slot gets read back. A mode switch that fails to clear the indices shows up on the cycle after the switch.

// File: rtl/nbr_queue_pkg.sv
package nbr_queue_pkg;

   typedef enum logic {
      NQ_MODE_LOCAL    = 1'b0,
      NQ_MODE_NEIGHBOR = 1'b1
   } nq_mode_e;

   function automatic bit nq_is_pow2(input int unsigned val);
      return (val != 0) && ((val & (val - 1)) == 0);
   endfunction

endpackage

// File: rtl/nbr_queue_store.sv
module nbr_queue_store #(
   parameter int unsigned ENTRIES       = 128,
   parameter int unsigned DATA_W        = 32,
   parameter bit          RESET_STORAGE = 1'b1,
   localparam int unsigned IDX_W        = $clog2(ENTRIES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [IDX_W-1:0]  rd_a_addr_i,
   output logic [DATA_W-1:0] rd_a_data_o,
   input  logic [IDX_W-1:0]  rd_b_addr_i,
   output logic [DATA_W-1:0] rd_b_data_o
);

   logic [DATA_W-1:0]  word_q [ENTRIES];
   logic [ENTRIES-1:0] slot_en;

   always_comb begin
      slot_en = '0;
      if (wr_en_i) slot_en[wr_addr_i] = 1'b1;
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      if (RESET_STORAGE) begin : g_rst
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)         word_q[e] <= '0;
            else if (slot_en[e]) word_q[e] <= wr_data_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk_i) begin
            if (slot_en[e]) word_q[e] <= wr_data_i;
         end
      end
   end

   assign rd_a_data_o = word_q[rd_a_addr_i];
   assign rd_b_data_o = word_q[rd_b_addr_i];

   // R2: the address decode never enables more than one slot
   assert_single_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(slot_en));

   // R2: a write is visible at the addressed slot on the next cycle
   assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && rd_a_addr_i == wr_addr_i && $stable(rd_a_addr_i)) |=>
         (rd_a_data_o == $past(wr_data_i)) || $past(rd_a_addr_i) != rd_a_addr_i);

endmodule

// File: rtl/nbr_queue_occupancy.sv
module nbr_queue_occupancy #(
   parameter int unsigned ENTRIES = 128,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic [IDX_W-1:0] put_i,
   input  logic [IDX_W-1:0] get_i,
   output logic             empty_o,
   output logic             full_o
);

   logic [IDX_W-1:0] put_next;

   assign put_next = put_i + IDX_W'(1);
   assign empty_o  = (put_i == get_i);
   assign full_o   = (put_next == get_i);

   // R5: the two flags can never be raised together
   always_comb begin
      assert_flags_exclusive_R5: assert (!(empty_o && full_o) || $isunknown(put_i));
   end

endmodule

// File: rtl/nbr_queue_index_ctrl.sv
module nbr_queue_index_ctrl
   import nbr_queue_pkg::*;
#(
   parameter int unsigned ENTRIES = 128,
   parameter int unsigned DATA_W  = 32,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_i,
   input  logic              loc_we_i,
   input  logic [IDX_W-1:0]  loc_waddr_i,
   input  logic [DATA_W-1:0] loc_wdata_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   input  logic              put_we_i,
   input  logic              get_we_i,
   input  logic [IDX_W-1:0]  idx_wdata_i,
   input  logic              empty_i,
   input  logic              full_i,
   output nq_mode_e          mode_o,
   output logic [IDX_W-1:0]  put_o,
   output logic [IDX_W-1:0]  get_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o
);

   nq_mode_e         mode_q;
   logic [IDX_W-1:0] put_q, get_q;
   logic             mode_chg, nbr_mode;
   logic             push_ok, pop_ok, loc_ok;

   assign mode_chg = (nq_mode_e'(mode_i) != mode_q);
   assign nbr_mode = (mode_q == NQ_MODE_NEIGHBOR);
   assign push_ok  = !mode_chg && nbr_mode && push_i && !full_i;
   assign pop_ok   = !mode_chg && nbr_mode && pop_i && !empty_i;
   assign loc_ok   = !mode_chg && !nbr_mode && loc_we_i;

   always_comb begin
      wr_en_o   = push_ok || loc_ok;
      wr_addr_o = push_ok ? put_q : loc_waddr_i;
      wr_data_o = push_ok ? push_data_i : loc_wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= NQ_MODE_LOCAL;
         put_q  <= '0;
         get_q  <= '0;
      end else if (mode_chg) begin
         mode_q <= nq_mode_e'(mode_i);
         put_q  <= '0;
         get_q  <= '0;
      end else begin
         if (put_we_i)     put_q <= idx_wdata_i;
         else if (push_ok) put_q <= put_q + IDX_W'(1);
         if (get_we_i)     get_q <= idx_wdata_i;
         else if (pop_ok)  get_q <= get_q + IDX_W'(1);
      end
   end

   assign mode_o = mode_q;
   assign put_o  = put_q;
   assign get_o  = get_q;

   assert_put_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nbr_mode && push_i && !full_i && !put_we_i && !mode_chg) |=>
         put_q == $past(put_q) + IDX_W'(1));

   assert_get_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (nbr_mode && pop_i && !empty_i && !get_we_i && !mode_chg) |=>
         get_q == $past(get_q) + IDX_W'(1));

   assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_i && !put_we_i && !mode_chg) |=> $stable(put_q));

   assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_i && !get_we_i && !mode_chg) |=> $stable(get_q));

   assert_sw_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (put_we_i && !mode_chg) |=> put_q == $past(idx_wdata_i));

   assert_mode_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_chg |=> (put_q == '0 && get_q == '0 && mode_q == nq_mode_e'($past(mode_i))));

   assert_local_ignores_queue_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!nbr_mode && !mode_chg && !put_we_i && !get_we_i) |=> ($stable(put_q) && $stable(get_q)));

endmodule

// File: rtl/nbr_queue_top.sv
module nbr_queue_top
   import nbr_queue_pkg::*;
#(
   parameter int unsigned ENTRIES       = 128,
   parameter int unsigned DATA_W        = 32,
   parameter bit          RESET_STORAGE = 1'b1,
   localparam int unsigned IDX_W        = $clog2(ENTRIES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mode_i,
   input  logic              loc_we_i,
   input  logic [IDX_W-1:0]  loc_waddr_i,
   input  logic [DATA_W-1:0] loc_wdata_i,
   input  logic [IDX_W-1:0]  loc_raddr_i,
   output logic [DATA_W-1:0] loc_rdata_o,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   input  logic              put_we_i,
   input  logic              get_we_i,
   input  logic [IDX_W-1:0]  idx_wdata_i,
   output logic [IDX_W-1:0]  put_idx_o,
   output logic [IDX_W-1:0]  get_idx_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              mode_o
);

   if (!nq_is_pow2(ENTRIES) || ENTRIES < 4) begin : g_bad_entries
      $error("nbr_queue_top: ENTRIES must be a power of two of at least 4");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("nbr_queue_top: DATA_W must be at least 1");
   end

   nq_mode_e          mode_cur;
   logic [IDX_W-1:0]  put_w, get_w;
   logic              empty_w, full_w;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_addr;
   logic [DATA_W-1:0] wr_data;

   nbr_queue_index_ctrl #(
      .ENTRIES (ENTRIES),
      .DATA_W  (DATA_W)
   ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode_i),
      .loc_we_i    (loc_we_i),
      .loc_waddr_i (loc_waddr_i),
      .loc_wdata_i (loc_wdata_i),
      .push_i      (push_i),
      .push_data_i (push_data_i),
      .pop_i       (pop_i),
      .put_we_i    (put_we_i),
      .get_we_i    (get_we_i),
      .idx_wdata_i (idx_wdata_i),
      .empty_i     (empty_w),
      .full_i      (full_w),
      .mode_o      (mode_cur),
      .put_o       (put_w),
      .get_o       (get_w),
      .wr_en_o     (wr_en),
      .wr_addr_o   (wr_addr),
      .wr_data_o   (wr_data)
   );

   nbr_queue_occupancy #(
      .ENTRIES (ENTRIES)
   ) u_occ (
      .put_i   (put_w),
      .get_i   (get_w),
      .empty_o (empty_w),
      .full_o  (full_w)
   );

   nbr_queue_store #(
      .ENTRIES       (ENTRIES),
      .DATA_W        (DATA_W),
      .RESET_STORAGE (RESET_STORAGE)
   ) u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .rd_a_addr_i (loc_raddr_i),
      .rd_a_data_o (loc_rdata_o),
      .rd_b_addr_i (get_w),
      .rd_b_data_o (pop_data_o)
   );

   assign put_idx_o = put_w;
   assign get_idx_o = get_w;
   assign empty_o   = empty_w;
   assign full_o    = full_w;
   assign mode_o    = mode_cur;

   // R8: a push and a pop accepted together move both indices
   assert_dual_op_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_cur == NQ_MODE_NEIGHBOR && mode_i && push_i && pop_i &&
       !empty_w && !full_w && !put_we_i && !get_we_i) |=>
         (put_w == $past(put_w) + IDX_W'(1) && get_w == $past(get_w) + IDX_W'(1)));

endmodule

// File: tb/nbr_queue_top_tb_top.sv
module nbr_queue_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_i = 1'b0, loc_we = 1'b0, push = 1'b0, pop = 1'b0;
   logic        put_we = 1'b0, get_we = 1'b0;
   logic [6:0]  loc_waddr = '0, loc_raddr = '0, idx_wdata = '0;
   logic [31:0] loc_wdata = '0, push_data = '0;
   logic [31:0] loc_rdata, pop_data;
   logic [6:0]  put_idx, get_idx;
   logic        empty, full, mode_o;

   logic [31:0] m_arr [N];
   logic [6:0]  m_put = '0, m_get = '0;
   logic        m_mode = 1'b0;
   int          n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nbr_queue_top dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode_i),
      .loc_we_i(loc_we), .loc_waddr_i(loc_waddr), .loc_wdata_i(loc_wdata),
      .loc_raddr_i(loc_raddr), .loc_rdata_o(loc_rdata),
      .push_i(push), .push_data_i(push_data), .pop_i(pop), .pop_data_o(pop_data),
      .put_we_i(put_we), .get_we_i(get_we), .idx_wdata_i(idx_wdata),
      .put_idx_o(put_idx), .get_idx_o(get_idx),
      .empty_o(empty), .full_o(full), .mode_o(mode_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic m_empty();
      return m_put == m_get;
   endfunction

   function automatic logic m_full();
      return 7'(m_put + 7'd1) == m_get;
   endfunction

   task automatic check_state(input string tag);
      chk({tag, " put"}, 32'(put_idx), 32'(m_put));
      chk({tag, " get"}, 32'(get_idx), 32'(m_get));
      chk({tag, " mode"}, 32'(mode_o), 32'(m_mode));
      chk("R5 empty", 32'(empty), 32'(m_empty()));
      chk("R5 full", 32'(full), 32'(m_full()));
      if (m_mode) chk("R4 pop_data", pop_data, m_arr[m_get]);
      chk("R2 loc_rdata", loc_rdata, m_arr[loc_raddr]);
   endtask

   // one clock: drive at negedge, check read paths, clock, update model, check
   task automatic step(input logic md, input logic lwe, input logic [6:0] lwa,
                       input logic [31:0] lwd, input logic [6:0] lra,
                       input logic ps, input logic [31:0] pd, input logic pp,
                       input logic pwe, input logic gwe, input logic [6:0] iw);
      string tag;
      logic chg, fl, em;
      logic [6:0] np, ng;
      mode_i = md; loc_we = lwe; loc_waddr = lwa; loc_wdata = lwd; loc_raddr = lra;
      push = ps; push_data = pd; pop = pp; put_we = pwe; get_we = gwe; idx_wdata = iw;
      #1;
      if (m_mode) chk("R4 pop_data comb", pop_data, m_arr[m_get]);
      chk("R2 loc_rdata comb", loc_rdata, m_arr[lra]);
      chg = (md != m_mode);
      fl = m_full(); em = m_empty();
      np = m_put; ng = m_get;
      if (chg)                      tag = "R10";
      else if (pwe || gwe)          tag = "R9";
      else if (!m_mode && (ps||pp)) tag = "R11";
      else if (m_mode && ps && fl)  tag = "R6";
      else if (m_mode && pp && em)  tag = "R7";
      else if (m_mode && ps && pp)  tag = "R8";
      else if (m_mode && pp)        tag = "R4";
      else if (m_mode && ps)        tag = "R3";
      else if (m_mode && lwe)       tag = "R11";
      else                          tag = "R2";
      @(posedge clk);
      if (chg) begin
         m_mode = md; np = '0; ng = '0;
      end else begin
         if (!m_mode && lwe) m_arr[lwa] = lwd;
         if (m_mode && ps && !fl) begin
            m_arr[m_put] = pd; np = m_put + 7'd1;
         end
         if (m_mode && pp && !em) ng = m_get + 7'd1;
         if (pwe) np = iw;
         if (gwe) ng = iw;
      end
      m_put = np; m_get = ng;
      @(negedge clk);
      check_state(tag);
   endtask

   task automatic idle(input logic md);
      step(md, 0, 0, 0, 7'($urandom), 0, 0, 0, 0, 0, 0);
   endtask

   task automatic do_push(input logic [31:0] d);
      step(1, 0, 0, 0, 7'($urandom), 1, d, 0, 0, 0, 0);
   endtask

   task automatic do_pop();
      step(1, 0, 0, 0, 7'($urandom), 0, 0, 1, 0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < N; i++) m_arr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check_state("R1");

      // R2: local writes and reads
      for (int i = 0; i < 40; i++)
         step(0, 1, 7'($urandom), $urandom, 7'($urandom), 0, 0, 0, 0, 0, 0);
      step(0, 1, 7'd127, 32'hdead_beef, 7'd127, 0, 0, 0, 0, 0, 0);
      idle(0);
      // R11: push and pop in local mode ignored
      step(0, 0, 0, 0, 7'd0, 1, 32'h1111_2222, 1, 0, 0, 0);
      step(0, 0, 0, 0, 7'd0, 1, 32'h3333_4444, 0, 0, 0, 0);

      // R10: switch to neighbor with prior index values
      step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 7'd33);
      step(1, 1, 7'd5, 32'h5, 7'd5, 1, 32'h77, 1, 1, 1, 7'd9);
      // R3: fill to full (127 entries)
      for (int i = 0; i < 127; i++) do_push(32'hA000_0000 + 32'(i));
      // R6: push while full dropped
      do_push(32'hBAD0_0001);
      do_push(32'hBAD0_0002);
      // R11: local write in neighbor mode ignored
      step(1, 1, 7'd3, 32'hFFFF_0000, 7'd3, 0, 0, 0, 0, 0, 0);
      // full with push and pop together: pop taken, push dropped
      step(1, 0, 0, 0, 0, 1, 32'hBAD0_0003, 1, 0, 0, 0);
      // R4: drain
      for (int i = 0; i < 130; i++) do_pop();
      // R7: pop while empty
      do_pop();

      // R9: software load to near wrap, then push across it
      step(1, 0, 0, 0, 0, 0, 0, 0, 1, 1, 7'd124);
      for (int i = 0; i < 8; i++) do_push(32'hC000_0000 + 32'(i));
      // R8: push and pop together mid-queue
      for (int i = 0; i < 10; i++)
         step(1, 0, 0, 0, 7'($urandom), 1, $urandom, 1, 0, 0, 0);
      // R9: load wins over auto-advance
      step(1, 0, 0, 0, 0, 1, 32'h9, 1, 1, 0, 7'd50);
      step(1, 0, 0, 0, 0, 1, 32'h9, 1, 0, 1, 7'd45);
      // R10: back to local clears indices
      idle(0);
      idle(0);

      // random phases with biased push/pop rates
      for (int ph = 0; ph < 12; ph++) begin
         int pp_push, pp_pop;
         pp_push = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 20 : 55;
         pp_pop  = (ph % 3 == 0) ? 15 : (ph % 3 == 1) ? 80 : 50;
         for (int i = 0; i < 250; i++) begin
            logic md;
            md = ($urandom_range(0, 199) == 0) ? ~m_mode : (ph == 5 ? 1'b0 : 1'b1);
            step(md, ($urandom_range(0, 99) < 20), 7'($urandom), $urandom, 7'($urandom),
                 ($urandom_range(0, 99) < pp_push), $urandom,
                 ($urandom_range(0, 99) < pp_pop),
                 ($urandom_range(0, 99) == 0), ($urandom_range(0, 99) == 0),
                 7'($urandom));
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
      $finish;
   end

endmodule